// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 64-bit execution core and a byte-addressed data memory port that is 64 bits wide. Each access arrives as an opcode, a size code, a sign flag, a base register value, a 16-bit offset and, for stores, a source register value. The unit adds the sign-extended offset to the base to form a 64-bit effective address. It checks the address against the access size. It then issues one request for the 8-byte line that contains the access, with per-byte enables.

For stores, the low bytes of the source register are moved onto the byte lanes that the address selects. For loads, the addressed bytes are taken out of the returned line and widened to 64 bits, with either sign or zero extension. A misaligned access is reported on a flag and never reaches memory. While an access is outstanding the unit reports busy and ignores new requests.

Top module: `lsu_align`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `misalign_o` and `load_valid_o` are all low.
- R2: The effective address is `base_i` plus `offset_i` sign-extended to 64 bits, with wraparound modulo 2^64. In the cycle after an access is accepted, `mem_req_o` is high for exactly one cycle and `mem_addr_o` holds the effective address with bits 2:0 cleared.
- R3: Size codes are 00 = byte, 01 = halfword, 10 = word and 11 = quadword. An access whose effective address is not a multiple of its byte count raises `misalign_o` for one cycle, in the cycle after acceptance. No `mem_req_o` follows it, and `busy_o` stays low.
- R4: `mem_be_o` bit i enables byte lane i, which is `mem_wdata_o`/`mem_rdata_i` bits 8i+7:8i (little-endian). The enabled lanes are the contiguous run of size bytes that starts at lane EA[2:0]. `mem_we_o` is high for stores and low for loads.
- R5: A store places the low size bytes of `wdata_i` on the enabled lanes, with the lowest byte on lane EA[2:0]. All lanes that are not enabled carry zero.
- R6: A load takes size bytes of `mem_rdata_i` starting at lane EA[2:0]. The byte on the lowest lane becomes the least significant byte of the result.
- R7: With `req_signed_i` = 1, byte, halfword and word loads copy the top bit of the loaded field into all higher result bits. With `req_signed_i` = 0 those bits are zero. For quadword loads the flag has no effect.
- R8: `load_valid_o` is high for exactly one cycle, the cycle after `mem_rvalid_i` completes a load, and `load_data_o` then holds the result. A completed store gives no `load_valid_o`.
- R9: `busy_o` is high from the cycle after an aligned access is accepted until the cycle after `mem_rvalid_i`. Requests that arrive while `busy_o` is high are dropped and never issued.
- R10: Opcode 6'b001001 is a load and 6'b001000 is a store. Any other opcode with `req_valid_i` high gives no request, no misalign flag and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| req_valid_i | input | 1 | Access request present |
| req_op_i | input | 6 | Major opcode (load or store) |
| req_size_i | input | 2 | Access size code |
| req_signed_i | input | 1 | Sign-extend load result |
| base_i | input | 64 | Base register value |
| offset_i | input | 16 | Signed address offset |
| wdata_i | input | 64 | Store source register value |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Line address (bits 2:0 zero) |
| mem_be_o | output | 8 | Byte enables, one per lane |
| mem_wdata_o | output | 64 | Lane-aligned store data |
| mem_rvalid_i | input | 1 | Memory response for outstanding access |
| mem_rdata_i | input | 64 | Returned memory line |
| busy_o | output | 1 | Access outstanding |
| misalign_o | output | 1 | Misaligned access rejected |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 64 | Extended load result |

## Verification
Each internal state shows up at the ports within one or two cycles. A captured address or size that is wrong shows up as a bad line address or bad enables in the request cycle. A wrong lane offset or extension mode corrupts `load_data_o` in the cycle after the response. An access state machine stuck outside idle keeps `busy_o` high and blocks every later request, so the next vector exposes it at once. A stale misalign or request register shows up as a second strobe in the cycle after the first.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_QUAD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } lsu_state_e;

  localparam logic [5:0] OPC_LOAD  = 6'b001001;
  localparam logic [5:0] OPC_STORE = 6'b001000;

endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  acc_size_e        size_i,
  output logic [XLEN-1:0]  ea_o,
  output logic             misaligned_o
);
  localparam int unsigned LANE_W = $clog2(XLEN / 8);

  logic [XLEN-1:0]   off_ext;
  logic [LANE_W:0]   nbytes;
  logic [LANE_W-1:0] low_mask;

  always_comb begin
    off_ext      = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    ea_o         = base_i + off_ext;
    nbytes       = {{LANE_W{1'b0}}, 1'b1} << size_i;
    low_mask     = LANE_W'(nbytes - 1'b1);
    misaligned_o = |(ea_o[LANE_W-1:0] & low_mask);
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  acc_size_e                     size_i,
  input  logic [$clog2(XLEN/8)-1:0]     lane_i,
  input  logic [XLEN-1:0]               wdata_i,
  output logic [XLEN/8-1:0]             be_o,
  output logic [XLEN-1:0]               data_o
);
  localparam int unsigned BE_W   = XLEN / 8;
  localparam int unsigned LANE_W = $clog2(BE_W);

  logic [LANE_W:0] nbytes;

  always_comb begin
    nbytes = {{LANE_W{1'b0}}, 1'b1} << size_i;
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [LANE_W-1:0] rel;
    logic              hit;
    always_comb begin
      rel = LANE_W'(g) - lane_i;
      hit = (LANE_W'(g) >= lane_i) && ({1'b0, rel} < nbytes);
    end
    assign be_o[g]          = hit;
    assign data_o[g*8 +: 8] = hit ? wdata_i[rel*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]           rdata_i,
  input  logic [$clog2(XLEN/8)-1:0] lane_i,
  input  acc_size_e                 size_i,
  input  logic                      signed_i,
  output logic [XLEN-1:0]           data_o
);
  logic [XLEN-1:0] shifted;

  always_comb begin
    shifted = rdata_i >> {lane_i, 3'b000};
    unique case (size_i)
      SZ_BYTE: data_o = {{(XLEN-8){signed_i & shifted[7]}},   shifted[7:0]};
      SZ_HALF: data_o = {{(XLEN-16){signed_i & shifted[15]}}, shifted[15:0]};
      SZ_WORD: data_o = {{(XLEN-32){signed_i & shifted[31]}}, shifted[31:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned OFF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [5:0]          req_op_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_signed_i,
  input  logic [XLEN-1:0]     base_i,
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [XLEN-1:0]     wdata_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [XLEN-1:0]     mem_addr_o,
  output logic [XLEN/8-1:0]   mem_be_o,
  output logic [XLEN-1:0]     mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [XLEN-1:0]     mem_rdata_i,
  output logic                busy_o,
  output logic                misalign_o,
  output logic                load_valid_o,
  output logic [XLEN-1:0]     load_data_o
);
  localparam int unsigned BE_W   = XLEN / 8;
  localparam int unsigned LANE_W = $clog2(BE_W);

  logic rst_int_n;

  lsu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Request decode
  acc_size_e  req_size;
  logic       op_load, op_store, accept, issue_ok, mis_hit;
  logic [XLEN-1:0] ea;
  logic       ea_mis;
  logic [BE_W-1:0] be_new;
  logic [XLEN-1:0] wdata_new;

  lsu_state_e state_q, state_d;

  assign req_size = acc_size_e'(req_size_i);

  lsu_ea_gen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_ea (
    .base_i       (base_i),
    .offset_i     (offset_i),
    .size_i       (req_size),
    .ea_o         (ea),
    .misaligned_o (ea_mis)
  );

  lsu_store_lanes #(.XLEN(XLEN)) u_st (
    .size_i  (req_size),
    .lane_i  (ea[LANE_W-1:0]),
    .wdata_i (wdata_i),
    .be_o    (be_new),
    .data_o  (wdata_new)
  );

  always_comb begin
    op_load  = (req_op_i == OPC_LOAD);
    op_store = (req_op_i == OPC_STORE);
    accept   = req_valid_i && (op_load || op_store) && (state_q == ST_IDLE);
    issue_ok = accept && !ea_mis;
    mis_hit  = accept && ea_mis;
  end

  // Captured access
  logic [XLEN-1:0] ea_q;
  acc_size_e       size_q;
  logic            sign_q, store_q;
  logic [BE_W-1:0] be_q;
  logic [XLEN-1:0] wdata_q;
  logic            mis_q;
  logic            rsp_done, ld_en;
  logic            ld_vld_q;
  logic [XLEN-1:0] ld_data_q, ld_data_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (issue_ok)     state_d = ST_ISSUE;
      ST_ISSUE: state_d = mem_rvalid_i ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (mem_rvalid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ea_q    <= '0;
      size_q  <= SZ_BYTE;
      sign_q  <= 1'b0;
      store_q <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (issue_ok) begin
      ea_q    <= ea;
      size_q  <= req_size;
      sign_q  <= req_signed_i;
      store_q <= op_store;
      be_q    <= be_new;
      wdata_q <= wdata_new;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mis_q <= 1'b0;
    else            mis_q <= mis_hit;
  end

  // Response path
  lsu_load_extract #(.XLEN(XLEN)) u_ld (
    .rdata_i  (mem_rdata_i),
    .lane_i   (ea_q[LANE_W-1:0]),
    .size_i   (size_q),
    .signed_i (sign_q),
    .data_o   (ld_data_d)
  );

  always_comb begin
    rsp_done = mem_rvalid_i && (state_q != ST_IDLE);
    ld_en    = rsp_done && !store_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ld_vld_q <= 1'b0;
    else            ld_vld_q <= ld_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  ld_data_q <= '0;
    else if (ld_en)  ld_data_q <= ld_data_d;
  end

  // Outputs
  assign mem_req_o    = (state_q == ST_ISSUE);
  assign mem_we_o     = mem_req_o && store_q;
  assign mem_addr_o   = {ea_q[XLEN-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_be_o     = be_q;
  assign mem_wdata_o  = wdata_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign misalign_o   = mis_q;
  assign load_valid_o = ld_vld_q;
  assign load_data_o  = ld_data_q;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic [XLEN-1:0]   mem_addr_o,
  input logic [XLEN/8-1:0] mem_be_o,
  input logic              mem_rvalid_i,
  input logic              busy_o,
  input logic              misalign_o,
  input logic              load_valid_o
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o); // R2
  AST_LINE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000)); // R2
  AST_MIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (!mem_req_o && !busy_o)); // R3
  AST_BE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == 4 || $countones(mem_be_o) == 8)); // R4
  AST_LOAD_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_o |-> $past(mem_rvalid_i)); // R8
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_o |=> !load_valid_o); // R8
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o); // R9
endmodule

bind lsu_align lsu_align_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .mem_rvalid_i (mem_rvalid_i),
  .busy_o       (busy_o),
  .misalign_o   (misalign_o),
  .load_valid_o (load_valid_o)
);

// File: tb/lsu_align_tb.sv
module lsu_align_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [5:0]  LD = 6'b001001;
  localparam logic [5:0]  ST = 6'b001000;
  localparam logic [63:0] RLINE = 64'h8877665544332211;

  typedef struct packed {
    logic [5:0]  op;
    logic [1:0]  size;
    logic        sgn;
    logic [63:0] base;
    logic [15:0] off;
    logic [63:0] wd;
    logic        mis;
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] wline;
    logic [63:0] ld;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{LD, 2'b11, 1'b0, 64'h1000, 16'h0008, 64'h0, 1'b0, 64'h1008, 8'hFF, 64'h0, 64'h8877665544332211},
    '{LD, 2'b10, 1'b1, 64'h2000, 16'hFFFC, 64'h0, 1'b0, 64'h1FF8, 8'hF0, 64'h0, 64'hFFFFFFFF88776655},
    '{LD, 2'b10, 1'b0, 64'h2000, 16'hFFFC, 64'h0, 1'b0, 64'h1FF8, 8'hF0, 64'h0, 64'h0000000088776655},
    '{LD, 2'b01, 1'b1, 64'h3006, 16'h0000, 64'h0, 1'b0, 64'h3000, 8'hC0, 64'h0, 64'hFFFFFFFFFFFF8877},
    '{LD, 2'b01, 1'b0, 64'h3006, 16'h0000, 64'h0, 1'b0, 64'h3000, 8'hC0, 64'h0, 64'h0000000000008877},
    '{LD, 2'b00, 1'b1, 64'h0007, 16'h0000, 64'h0, 1'b0, 64'h0000, 8'h80, 64'h0, 64'hFFFFFFFFFFFFFF88},
    '{LD, 2'b00, 1'b0, 64'h4003, 16'h0000, 64'h0, 1'b0, 64'h4000, 8'h08, 64'h0, 64'h0000000000000044},
    '{LD, 2'b11, 1'b1, 64'h8000, 16'h7FF8, 64'h0, 1'b0, 64'hFFF8, 8'hFF, 64'h0, 64'h8877665544332211},
    '{ST, 2'b11, 1'b0, 64'h0100, 16'h0010, 64'h0123456789ABCDEF, 1'b0, 64'h0110, 8'hFF, 64'h0123456789ABCDEF, 64'h0},
    '{ST, 2'b10, 1'b0, 64'h0200, 16'h0004, 64'hDEADBEEFCAFEF00D, 1'b0, 64'h0200, 8'hF0, 64'hCAFEF00D00000000, 64'h0},
    '{ST, 2'b01, 1'b0, 64'h0302, 16'h0000, 64'h111122223333ABCD, 1'b0, 64'h0300, 8'h0C, 64'h00000000ABCD0000, 64'h0},
    '{ST, 2'b00, 1'b0, 64'h0405, 16'h0000, 64'hFFFFFFFFFFFFFF5A, 1'b0, 64'h0400, 8'h20, 64'h00005A0000000000, 64'h0},
    '{LD, 2'b10, 1'b0, 64'h1000, 16'h0002, 64'h0, 1'b1, 64'h0, 8'h00, 64'h0, 64'h0},
    '{ST, 2'b11, 1'b0, 64'h0104, 16'h0000, 64'h0, 1'b1, 64'h0, 8'h00, 64'h0, 64'h0},
    '{LD, 2'b01, 1'b1, 64'h0001, 16'h0000, 64'h0, 1'b1, 64'h0, 8'h00, 64'h0, 64'h0},
    '{LD, 2'b11, 1'b0, 64'h0000, 16'h8000, 64'h0, 1'b0, 64'hFFFFFFFFFFFF8000, 8'hFF, 64'h0, 64'h8877665544332211}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [5:0]  req_op_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_signed_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [63:0] wdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, misalign_o, load_valid_o;
  logic [63:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [7:0]  mem_be_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid_i (req_valid_i), .req_op_i (req_op_i), .req_size_i (req_size_i),
    .req_signed_i (req_signed_i), .base_i (base_i), .offset_i (offset_i),
    .wdata_i (wdata_i), .mem_req_o (mem_req_o), .mem_we_o (mem_we_o),
    .mem_addr_o (mem_addr_o), .mem_be_o (mem_be_o), .mem_wdata_o (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i), .mem_rdata_i (mem_rdata_i), .busy_o (busy_o),
    .misalign_o (misalign_o), .load_valid_o (load_valid_o), .load_data_o (load_data_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [1:0] sz, input logic sg,
                       input logic [63:0] b, input logic [15:0] o, input logic [63:0] w);
    req_valid_i = 1'b1; req_op_i = op; req_size_i = sz; req_signed_i = sg;
    base_i = b; offset_i = o; wdata_i = w;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 mem_req", 64'(mem_req_o), 64'd0);
    chk("R1 misalign", 64'(misalign_o), 64'd0);
    chk("R1 load_valid", 64'(load_valid_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].size, VEC[i].sgn, VEC[i].base, VEC[i].off, VEC[i].wd);
      @(negedge clk);
      req_valid_i = 1'b0;
      if (VEC[i].mis) begin
        chk("R3 misalign", 64'(misalign_o), 64'd1);
        chk("R3 no req", 64'(mem_req_o), 64'd0);
        chk("R3 no busy", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk("R3 still no req", 64'(mem_req_o), 64'd0);
      end else begin
        chk("R2 req", 64'(mem_req_o), 64'd1);
        chk("R2 addr", mem_addr_o, VEC[i].addr);
        chk("R4 be", 64'(mem_be_o), 64'(VEC[i].be));
        chk("R4 we", 64'(mem_we_o), 64'(VEC[i].op == ST));
        chk("R9 busy", 64'(busy_o), 64'd1);
        if (VEC[i].op == ST) chk("R5 wdata", mem_wdata_o, VEC[i].wline);
        mem_rvalid_i = 1'b1; mem_rdata_i = RLINE;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        chk("R9 busy drop", 64'(busy_o), 64'd0);
        chk("R2 one-cycle req", 64'(mem_req_o), 64'd0);
        if (VEC[i].op == LD) begin
          chk("R8 load_valid", 64'(load_valid_o), 64'd1);
          chk("R6/R7 load_data", load_data_o, VEC[i].ld);
        end else begin
          chk("R8 no load_valid on store", 64'(load_valid_o), 64'd0);
        end
        @(negedge clk);
      end
    end

    // R10: foreign opcode, misaligned address, must stay silent
    drive(6'b000000, 2'b11, 1'b0, 64'h1, 16'h0, 64'h0);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10 no req", 64'(mem_req_o), 64'd0);
    chk("R10 no misalign", 64'(misalign_o), 64'd0);
    chk("R10 no busy", 64'(busy_o), 64'd0);

    // R9: request while busy is dropped
    drive(LD, 2'b10, 1'b0, 64'h2004, 16'h0, 64'h0);
    @(negedge clk);
    chk("R9 first req", 64'(mem_req_o), 64'd1);
    drive(ST, 2'b11, 1'b0, 64'h500, 16'h0, 64'hAAAA);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 blocked req", 64'(mem_req_o), 64'd0);
      chk("R9 held busy", 64'(busy_o), 64'd1);
    end
    req_valid_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = RLINE;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk("R8 late load_valid", 64'(load_valid_o), 64'd1);
    chk("R6 late load_data", load_data_o, 64'h0000000088776655);
    @(negedge clk);
    chk("R8 pulse ends", 64'(load_valid_o), 64'd0);
    chk("R9 dropped store never issued", 64'(mem_req_o), 64'd0);
    chk("R9 idle after", 64'(busy_o), 64'd0);

    finish_run();
  end
endmodule